// File: doc/BRIEF.md
# Programmable ATA Strobe Timing Generator

This block drives the read and write strobes of a parallel ATA channel that carries two devices. Each device owns a 32-bit timing word. The word holds separate counts for data transfers (PIO or multiword DMA) and for task-file register accesses. Each set has a first-cycle setup interval, an active (strobe low) time and an inactive (recovery) time. All counts are in core clock cycles.

A host presents requests on a valid/ready handshake. Each request carries a device number, a direction, a data-versus-task-file flag and an end-of-burst flag. The sequencer takes its counts from the selected word when it accepts the request. It then walks through setup, active and recovery phases. On a read it captures the bus word at the moment the strobe rises and reports completion with a one-cycle pulse. Requests that follow inside a burst skip the setup interval but still honour the full recovery time.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both timing words read as zero, both strobes are high, `done_o` is low and `req_ready_o` is high. With zero timing, a read strobes for exactly one cycle, starting on the cycle after acceptance.
- R2: A configuration write to word address n stores the word for device n. `cfg_rdata_o` returns the word at `cfg_addr_i`, and the two devices' words are independent (byte offsets 0 and 4).
- R3: A data transfer holds its strobe low for bits [7:4] + 1 cycles.
- R4: After a data transfer the strobe stays high for bits [3:0] + 1 cycles before another strobe can fall.
- R5: A task-file access holds its strobe low for bits [15:12] + 1 cycles and then high for bits [11:8] + 1 cycles.
- R6: The first data transfer of a burst waits bits [21:19] = N cycles with both strobes high after acceptance. N = 0 lowers the strobe on the cycle right after acceptance.
- R7: The first task-file access of a burst waits bits [24:22] cycles with both strobes high.
- R8: A request with `req_last_i` = 0 opens or continues a burst. The next request is accepted in the last recovery cycle and skips setup. Outside a burst, `req_ready_o` is low in that cycle and the next request pays its setup again. `req_ready_o` is never high while a strobe is low.
- R9: `done_o` is a one-cycle pulse in the first cycle after the strobe rises. For a read, `rd_data_o` then holds the bus value sampled at that rising edge and keeps it until the next completion.
- R10: `xfer_dma_o` is high from acceptance to the end of recovery for a data transfer whose device word has bit 29 set. It is low for task-file accesses and when bit 29 is clear.
- R11: Writes pulse only `ata_diow_no` and present the request data on `ata_wdata_o`. Reads pulse only `ata_dior_no`. The two strobes are never low together, and `ata_dev_o` shows the device of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing word write enable |
| cfg_addr_i | input | DEV_W | Timing word index (device number) |
| cfg_wdata_i | input | 32 | Timing word write data |
| cfg_rdata_o | output | 32 | Timing word at `cfg_addr_i` |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_dev_i | input | DEV_W | Target device |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_taskfile_i | input | 1 | 1 = task-file access, 0 = data transfer |
| req_last_i | input | 1 | Request closes the burst |
| req_wdata_i | input | DATA_W | Write data |
| ata_dior_no | output | 1 | Read strobe, active low |
| ata_diow_no | output | 1 | Write strobe, active low |
| ata_dev_o | output | DEV_W | Device of the current request |
| ata_wdata_o | output | DATA_W | Data driven for a write |
| ata_rdata_i | input | DATA_W | Data bus input for reads |
| xfer_dma_o | output | 1 | Current data transfer runs in multiword DMA timing |
| rd_data_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupt phase counter or state shows up at the ports within one strobe period. It appears as a strobe edge that is one or more cycles early or late, a missing or doubled `done_o`, or `req_ready_o` opening at the wrong recovery cycle. A wrongly latched timing field or device select shows on the very next transfer, because every expected edge is derived from the bench's own copy of the programmed words. A burst-tracking fault shows as a setup gap that appears or vanishes between back-to-back requests, and each cycle is compared as it occurs.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOVER
  } seq_state_e;

  typedef struct packed {
    logic       dma;
    logic [2:0] setup;
    logic [3:0] act;
    logic [3:0] rec;
  } phase_cfg_t;

  typedef struct packed {
    phase_cfg_t data;
    phase_cfg_t tf;
  } dev_cfg_t;

  function automatic dev_cfg_t unpack_timing(input logic [REG_W-1:0] w);
    dev_cfg_t c;
    c.data.dma   = w[29];
    c.data.setup = w[21:19];
    c.data.act   = w[7:4];
    c.data.rec   = w[3:0];
    c.tf.dma     = 1'b0;
    c.tf.setup   = w[24:22];
    c.tf.act     = w[15:12];
    c.tf.rec     = w[11:8];
    return c;
  endfunction
endpackage

// File: rtl/ata_timing_regs.sv
module ata_timing_regs
  import ata_strobe_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2,
  parameter int unsigned DEV_W   = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [DEV_W-1:0]              addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output dev_cfg_t [NUM_DEV-1:0]        dev_cfg_o
);
  logic [NUM_DEV-1:0][REG_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (addr_i == DEV_W'(d)) regs_q[d] <= wdata_i;
      end
    end
  end

  assign rdata_o = regs_q[addr_i];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_unpack
    assign dev_cfg_o[d] = unpack_timing(regs_q[d]);
  end
endmodule

// File: rtl/ata_timing_sel.sv
module ata_timing_sel
  import ata_strobe_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2,
  parameter int unsigned DEV_W   = 1
) (
  input  dev_cfg_t [NUM_DEV-1:0] dev_cfg_i,
  input  logic [DEV_W-1:0]       dev_i,
  input  logic                   tf_i,
  output phase_cfg_t             cfg_o
);
  dev_cfg_t sel;

  assign sel   = dev_cfg_i[dev_i];
  assign cfg_o = tf_i ? sel.tf : sel.data;
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEV_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic              req_write_i,
  input  logic              req_last_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  phase_cfg_t        cfg_i,
  output logic              dior_no,
  output logic              diow_no,
  output logic [DEV_W-1:0]  dev_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              dma_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        act_q, rec_q;
  logic              dma_q, wr_q, burst_q, done_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              cnt_zero, accept, strobe_on;

  assign cnt_zero    = (cnt_q == '0);
  // next request may enter in the last recovery cycle only inside a burst
  assign req_ready_o = (state_q == ST_IDLE) ||
                       ((state_q == ST_RECOVER) && cnt_zero && burst_q);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      dma_q   <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      dev_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        act_q   <= cfg_i.act;
        rec_q   <= cfg_i.rec;
        dma_q   <= cfg_i.dma;
        wr_q    <= req_write_i;
        dev_q   <= req_dev_i;
        wdata_q <= req_wdata_i;
        burst_q <= !req_last_i;
        if (burst_q || (cfg_i.setup == '0)) begin
          state_q <= ST_ACTIVE;
          cnt_q   <= CNT_W'(cfg_i.act);
        end else begin
          state_q <= ST_SETUP;
          cnt_q   <= CNT_W'(cfg_i.setup) - CNT_W'(1);
        end
      end else begin
        unique case (state_q)
          ST_SETUP: begin
            if (cnt_zero) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= CNT_W'(act_q);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          ST_ACTIVE: begin
            if (cnt_zero) begin
              state_q <= ST_RECOVER;
              cnt_q   <= CNT_W'(rec_q);
              done_q  <= 1'b1;
              if (!wr_q) rdata_q <= rdata_i;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          ST_RECOVER: begin
            if (cnt_zero) state_q <= ST_IDLE;
            else          cnt_q   <= cnt_q - CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign strobe_on = (state_q == ST_ACTIVE);
  assign dior_no   = !(strobe_on && !wr_q);
  assign diow_no   = !(strobe_on && wr_q);
  assign dma_o     = (state_q != ST_IDLE) && dma_q;
  assign dev_o     = dev_q;
  assign wdata_o   = wdata_q;
  assign rd_data_o = rdata_q;
  assign done_o    = done_q;
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter  int unsigned NUM_DEV = 2,
  parameter  int unsigned DATA_W  = 16,
  localparam int unsigned DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DEV_W-1:0]  cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic              req_write_i,
  input  logic              req_taskfile_i,
  input  logic              req_last_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ata_dior_no,
  output logic              ata_diow_no,
  output logic [DEV_W-1:0]  ata_dev_o,
  output logic [DATA_W-1:0] ata_wdata_o,
  input  logic [DATA_W-1:0] ata_rdata_i,
  output logic              xfer_dma_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  dev_cfg_t [NUM_DEV-1:0] dev_cfg;
  phase_cfg_t             req_cfg;

  ata_timing_regs #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .dev_cfg_o (dev_cfg)
  );

  ata_timing_sel #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_sel (
    .dev_cfg_i (dev_cfg),
    .dev_i     (req_dev_i),
    .tf_i      (req_taskfile_i),
    .cfg_o     (req_cfg)
  );

  ata_strobe_seq #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_dev_i   (req_dev_i),
    .req_write_i (req_write_i),
    .req_last_i  (req_last_i),
    .req_wdata_i (req_wdata_i),
    .cfg_i       (req_cfg),
    .dior_no     (ata_dior_no),
    .diow_no     (ata_diow_no),
    .dev_o       (ata_dev_o),
    .wdata_o     (ata_wdata_o),
    .rdata_i     (ata_rdata_i),
    .dma_o       (xfer_dma_o),
    .rd_data_o   (rd_data_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              ata_dior_no,
  input logic              ata_diow_no,
  input logic              done_o,
  input logic [DATA_W-1:0] rd_data_o
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ata_dior_no && !ata_diow_no));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(ata_dior_no) || $rose(ata_diow_no)));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_data_o));

  // R8
  no_ready_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ata_dior_no || !ata_diow_no) |-> !req_ready_o);
endmodule

bind ata_strobe_gen ata_strobe_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ata_strobe_gen.sv
module tb_ata_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [0:0]  req_dev = '0;
  logic        req_write = 1'b0, req_tf = 1'b0, req_last = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        dior_n, diow_n, xfer_dma, done;
  logic [0:0]  ata_dev;
  logic [15:0] ata_wdata, ata_rdata = '0, rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] mreg [2];
  bit m_burst = 1'b0;
  bit at_last_rec = 1'b0;

  always #5 clk = ~clk;

  ata_strobe_gen dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_dev_i(req_dev),
    .req_write_i(req_write), .req_taskfile_i(req_tf), .req_last_i(req_last),
    .req_wdata_i(req_wdata),
    .ata_dior_no(dior_n), .ata_diow_no(diow_n), .ata_dev_o(ata_dev),
    .ata_wdata_o(ata_wdata), .ata_rdata_i(ata_rdata),
    .xfer_dma_o(xfer_dma), .rd_data_o(rd_data), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cfg_write(input logic [0:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mreg[a] = d;
    at_last_rec = 1'b0;
  endtask

  // Reference model: expected waveform derived from the programmed words
  task automatic xfer(input bit dev, input bit wr, input bit tf, input bit last,
                      input logic [15:0] wd, input logic [15:0] rd);
    int su, ac, rc;
    bit dma, skip;
    string ts, ta, tr;
    su  = tf ? int'(mreg[dev][24:22]) : int'(mreg[dev][21:19]);
    ac  = tf ? int'(mreg[dev][15:12]) : int'(mreg[dev][7:4]);
    rc  = tf ? int'(mreg[dev][11:8])  : int'(mreg[dev][3:0]);
    dma = !tf && mreg[dev][29];
    ts  = tf ? "R7 tf setup" : "R6 data setup";
    ta  = tf ? "R5 tf active" : "R3 data active";
    tr  = tf ? "R5 tf recovery" : "R4 data recovery";
    skip = m_burst;
    if (at_last_rec && !m_burst) begin
      chk("R8 ready low in last recovery outside burst", req_ready, 0);
      @(negedge clk);
    end
    chk("R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_dev = dev; req_write = wr; req_tf = tf;
    req_last = last; req_wdata = wd; ata_rdata = rd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wd;
    m_burst = !last;
    if (skip) su = 0;
    for (int i = 0; i < su; i++) begin
      chk({ts, " dior"}, dior_n, 1);
      chk({ts, " diow"}, diow_n, 1);
      chk("R10 dma flag", xfer_dma, dma);
      @(negedge clk);
    end
    for (int i = 0; i <= ac; i++) begin
      chk({ta, " active strobe"}, wr ? diow_n : dior_n, 0);
      chk("R11 idle strobe", wr ? dior_n : diow_n, 1);
      chk("R11 device", ata_dev, dev);
      chk("R10 dma flag", xfer_dma, dma);
      chk("R8 ready low while strobing", req_ready, 0);
      chk("R9 no done while active", done, 0);
      if (wr) chk("R11 write data", ata_wdata, wd);
      @(negedge clk);
    end
    chk("R9 done pulse", done, 1);
    chk({tr, " dior"}, dior_n, 1);
    chk({tr, " diow"}, diow_n, 1);
    if (!wr) chk("R9 read data", rd_data, rd);
    ata_rdata = ~rd;
    for (int j = 0; j < rc; j++) begin
      @(negedge clk);
      chk({tr, " dior"}, dior_n, 1);
      chk({tr, " diow"}, diow_n, 1);
      chk("R9 done single", done, 0);
      chk("R10 dma flag", xfer_dma, dma);
      if (!wr) chk("R9 read data held", rd_data, rd);
    end
    at_last_rec = 1'b1;
  endtask

  initial begin
    mreg[0] = '0; mreg[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 dior high", dior_n, 1);
    chk("R1 diow high", diow_n, 1);
    chk("R1 ready", req_ready, 1);
    chk("R1 done low", done, 0);
    cfg_addr = 1'b0; #1;
    chk("R1 word0 zero", cfg_rdata, 0);
    cfg_addr = 1'b1; #1;
    chk("R1 word1 zero", cfg_rdata, 0);
    @(negedge clk);
    // R1 zero timing: one-cycle strobe right after acceptance
    xfer(0, 0, 0, 1, 16'h0, 16'h5a5a);

    // dev0: data setup 3 act 5 rec 2, tf setup 2 act 1 rec 3, PIO
    cfg_write(1'b0, (32'd2 << 22) | (32'd3 << 19) | (32'd1 << 12) | (32'd3 << 8) | (32'd5 << 4) | 32'd2);
    // dev1: data setup 1 act 2 rec 4, tf setup 5 act 3 rec 1, multiword DMA
    cfg_write(1'b1, (32'd1 << 29) | (32'd5 << 22) | (32'd1 << 19) | (32'd3 << 12) | (32'd1 << 8) | (32'd2 << 4) | 32'd4);
    cfg_addr = 1'b0; #1;
    chk("R2 word0 readback", cfg_rdata, mreg[0]);
    cfg_addr = 1'b1; #1;
    chk("R2 word1 readback", cfg_rdata, mreg[1]);

    xfer(0, 0, 0, 1, 16'h0, 16'h1234);     // R3 R4 R6 data read, PIO
    xfer(1, 1, 0, 1, 16'hbeef, 16'h0);     // R10 R11 data write, DMA
    xfer(1, 0, 1, 1, 16'h0, 16'hc0de);     // R5 R7 task-file read
    xfer(0, 1, 1, 1, 16'h7e57, 16'h0);     // R5 R7 task-file write
    // R8 burst: setup only on the first request
    xfer(0, 0, 0, 0, 16'h0, 16'h1111);
    xfer(1, 1, 0, 0, 16'h2222, 16'h0);
    xfer(0, 0, 1, 1, 16'h0, 16'h3333);
    xfer(1, 0, 0, 1, 16'h0, 16'h4444);     // R8 setup again after burst end
    repeat (3) @(negedge clk);
    chk("R8 idle ready", req_ready, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule